// File: doc/BRIEF.md
# SPI Transmit FIFO with Underflow Replay

This block buffers outgoing words for an SPI port acting as the peripheral on the bus. A processor-side producer pushes 16-bit words over a valid/ready channel into a four-entry first-in first-out store. On the shifter side, a one-cycle frame-start strobe takes the oldest stored word. The selected word appears on a registered output one cycle later, together with a one-cycle valid pulse. The shifter side cannot stall: every frame start is served.

If a frame starts while the store holds nothing, the block does not emit stale or zero data. It emits again the last word it ever accepted, and it sets a sticky underflow flag that software clears with a one-cycle strobe. Level-sensitive status pins report empty and not-full. An empty interrupt line and an empty DMA request line each follow the empty condition under their own enable.

Back-pressure rules for the write channel: `wr_ready` is high exactly when the store has a free entry. A word is taken on a clock edge where `wr_valid` and `wr_ready` are both high. A word offered while `wr_ready` is low is not taken and changes nothing. The producer may hold `wr_valid` high across cycles.

Top module: `spi_tx_replay_fifo`

## Requirements
- R1: After reset the store is empty (`tfe`=1, `tnf`=1), `unf_irq`=0 and `pop_valid`=0, and the replay word is 0x0000.
- R2: Accepted words leave in the order they were accepted, and up to 4 words are held at once.
- R3: While 4 words are held, `wr_ready` is 0. A word offered then is dropped: it is never emitted, and it does not become the replay word.
- R4: A `pop_req` strobe in cycle N gives `pop_valid`=1 with the word on `pop_data` in cycle N+1. With no strobe, `pop_valid` is 0.
- R5: A `pop_req` while empty emits the most recently accepted word and removes nothing. A word accepted in that same cycle is stored, and it is emitted by the next strobe.
- R6: A `pop_req` while empty sets `unf_irq` from the next cycle. `unf_irq` stays 1 until a cycle with `unf_clr`=1 and no new underflow. When a clear and an underflow fall in the same cycle, the flag stays 1.
- R7: `tfe` is 1 exactly when no word is held, and `tnf` is 1 exactly when fewer than 4 words are held. Both are updated in the cycle after the edge that changes the fill level.
- R8: `empty_irq` equals `tfe` AND `irq_en`, and `dma_req` equals `tfe` AND `dma_en`. Both are levels that hold for as long as the condition lasts.
- R9: An accepted write and a `pop_req` in the same cycle on a store that is neither empty nor full leave the fill level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Producer offers a word |
| wr_data | input | DATA_W | Word offered |
| wr_ready | output | 1 | Store can accept a word |
| pop_req | input | 1 | Frame-start strobe from the shifter |
| pop_valid | output | 1 | Pulse: `pop_data` holds the word for the frame |
| pop_data | output | DATA_W | Word to shift out |
| tfe | output | 1 | Store empty |
| tnf | output | 1 | Store not full |
| irq_en | input | 1 | Enable for the empty interrupt |
| dma_en | input | 1 | Enable for the empty DMA request |
| empty_irq | output | 1 | Empty interrupt level |
| dma_req | output | 1 | Empty DMA request level |
| unf_clr | input | 1 | One-cycle clear of the underflow flag |
| unf_irq | output | 1 | Sticky underflow flag |

## Verification
The cycle that needs the most care is one in which a frame start on an empty store falls together with an accepted write. In that cycle the emitted word must be the earlier replay value and not the word arriving, underflow must be raised, and the new word must stay stored for the next frame. The bench provokes this by driving `wr_valid` and `pop_req` together right after the store is drained. A scoreboard of expected words judges the output. A second collision places `unf_clr` in the same cycle as a fresh underflow and checks that the flag stays set.

// File: rtl/spi_txf_pkg.sv
package spi_txf_pkg;
  typedef struct packed {
    logic empty;
    logic full;
  } txf_level_t;

  typedef struct packed {
    logic push;
    logic pop;
    logic underflow;
  } txf_evt_t;
endpackage

// File: rtl/spi_txf_store.sv
module spi_txf_store
  import spi_txf_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head_data,
  output txf_level_t        level
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  fill;

  function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push) wr_ptr <= next_ptr(wr_ptr);
      if (pop)  rd_ptr <= next_ptr(rd_ptr);
      case ({push, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  assign head_data   = mem[rd_ptr];
  assign level.empty = (fill == '0);
  assign level.full  = (fill == FULL_CNT);
endmodule

// File: rtl/spi_txf_replay.sv
module spi_txf_replay #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              frame_start,
  input  logic              was_empty,
  input  logic [DATA_W-1:0] head_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  logic [DATA_W-1:0] last_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_word <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (push) last_word <= push_data;
      out_valid <= frame_start;
      if (frame_start) out_data <= was_empty ? last_word : head_data;
    end
  end
endmodule

// File: rtl/spi_txf_events.sv
module spi_txf_events
  import spi_txf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  txf_level_t level,
  input  txf_evt_t   evt,
  input  logic       irq_en,
  input  logic       dma_en,
  input  logic       unf_clr,
  output logic       empty_irq,
  output logic       dma_req,
  output logic       unf_irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) unf_irq <= 1'b0;
    else        unf_irq <= (unf_irq & ~unf_clr) | evt.underflow;
  end

  assign empty_irq = level.empty & irq_en;
  assign dma_req   = level.empty & dma_en;
endmodule

// File: rtl/spi_tx_replay_fifo.sv
module spi_tx_replay_fifo
  import spi_txf_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  input  logic              pop_req,
  output logic              pop_valid,
  output logic [DATA_W-1:0] pop_data,
  output logic              tfe,
  output logic              tnf,
  input  logic              irq_en,
  input  logic              dma_en,
  output logic              empty_irq,
  output logic              dma_req,
  input  logic              unf_clr,
  output logic              unf_irq
);
  txf_level_t        level;
  txf_evt_t          evt;
  logic [DATA_W-1:0] head_data;

  always_comb begin
    evt.push      = wr_valid & ~level.full;
    evt.pop       = pop_req & ~level.empty;
    evt.underflow = pop_req & level.empty;
  end

  spi_txf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (evt.push),
    .push_data (wr_data),
    .pop       (evt.pop),
    .head_data (head_data),
    .level     (level)
  );

  spi_txf_replay #(.DATA_W(DATA_W)) u_replay (
    .clk         (clk),
    .rst_n       (rst_n),
    .push        (evt.push),
    .push_data   (wr_data),
    .frame_start (pop_req),
    .was_empty   (level.empty),
    .head_data   (head_data),
    .out_valid   (pop_valid),
    .out_data    (pop_data)
  );

  spi_txf_events u_events (
    .clk       (clk),
    .rst_n     (rst_n),
    .level     (level),
    .evt       (evt),
    .irq_en    (irq_en),
    .dma_en    (dma_en),
    .unf_clr   (unf_clr),
    .empty_irq (empty_irq),
    .dma_req   (dma_req),
    .unf_irq   (unf_irq)
  );

  assign wr_ready = ~level.full;
  assign tfe      = level.empty;
  assign tnf      = ~level.full;
endmodule

// File: rtl/spi_txf_checker.sv
module spi_txf_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic [DATA_W-1:0] wr_data,
  input logic              wr_ready,
  input logic              pop_req,
  input logic              pop_valid,
  input logic [DATA_W-1:0] pop_data,
  input logic              tfe,
  input logic              tnf,
  input logic              irq_en,
  input logic              dma_en,
  input logic              empty_irq,
  input logic              dma_req,
  input logic              unf_clr,
  input logic              unf_irq
);
  a_r4_valid_after_pop: assert property (@(posedge clk) disable iff (!rst_n)
    pop_req |=> pop_valid);
  a_r4_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !pop_req |=> !pop_valid);
  a_r6_unf_raised: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && tfe) |=> unf_irq);
  a_r6_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (unf_irq && !unf_clr) |=> unf_irq);
  a_r3_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!tnf && !pop_req) |=> !tnf);
  a_r5_empty_pop_keeps_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (tfe && pop_req && !wr_valid) |=> tfe);
  a_r7_flags_consistent: assert property (@(posedge clk) disable iff (!rst_n)
    !(tfe && !tnf));
  a_r9_balanced_keeps_level: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && wr_valid && wr_ready && !tfe) |=> ($stable(tfe) && $stable(tnf)));
endmodule

bind spi_tx_replay_fifo spi_txf_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/test_spi_tx_replay_fifo.sv
module test_spi_tx_replay_fifo;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [15:0] wr_data = '0;
  logic        wr_ready;
  logic        pop_req = 1'b0;
  logic        pop_valid;
  logic [15:0] pop_data;
  logic        tfe, tnf;
  logic        irq_en = 1'b0;
  logic        dma_en = 1'b0;
  logic        empty_irq, dma_req;
  logic        unf_clr = 1'b0;
  logic        unf_irq;

  int vectors = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic [15:0] mdl_q[$];
  logic [15:0] sb_q[$];
  logic [15:0] mdl_last = 16'h0000;
  bit          mdl_unf = 1'b0;
  int          seen = 0;

  always #2 clk = ~clk;

  spi_tx_replay_fifo i_spi_tx_replay_fifo (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .pop_req(pop_req), .pop_valid(pop_valid),
    .pop_data(pop_data), .tfe(tfe), .tnf(tnf), .irq_en(irq_en),
    .dma_en(dma_en), .empty_irq(empty_irq), .dma_req(dma_req),
    .unf_clr(unf_clr), .unf_irq(unf_irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor: compares every emitted word against the scoreboard (R2, R4, R5)
  always @(negedge clk) begin
    if (rst_n && pop_valid) begin
      seen++;
      if (sb_q.size() == 0) begin
        vectors++; fails++;
        $display("FAIL R4: actual %0h expected none (unexpected pop_valid)", pop_data);
      end else begin
        check("R2/R5 pop_data", {16'h0, pop_data}, {16'h0, sb_q.pop_front()});
      end
    end
  end

  task automatic check_flags();
    int n = mdl_q.size();
    check("R7 tfe", tfe, n == 0);
    check("R7 tnf", tnf, n < 4);
    check("R3 wr_ready", wr_ready, n < 4);
    check("R8 empty_irq", empty_irq, (n == 0) && irq_en);
    check("R8 dma_req", dma_req, (n == 0) && dma_en);
    check("R6 unf_irq", unf_irq, mdl_unf);
  endtask

  // Driver: one cycle of stimulus, model updated as the requirements state
  task automatic step(input bit wv, input logic [15:0] wd, input bit pr, input bit clr);
    bit was_empty = (mdl_q.size() == 0);
    bit accept = wv && (mdl_q.size() < 4);
    wr_valid = wv; wr_data = wd; pop_req = pr; unf_clr = clr;
    if (pr) begin
      if (was_empty) sb_q.push_back(mdl_last);
      else           sb_q.push_back(mdl_q.pop_front());
    end
    mdl_unf = (mdl_unf && !clr) || (pr && was_empty);
    if (accept) begin
      mdl_q.push_back(wd);
      mdl_last = wd;
    end
    @(negedge clk);
    wr_valid = 1'b0; pop_req = 1'b0; unf_clr = 1'b0;
    check_flags();
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      vectors++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 tfe", tfe, 1'b1);
    check("R1 tnf", tnf, 1'b1);
    check("R1 unf_irq", unf_irq, 1'b0);
    check("R1 pop_valid", pop_valid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1/R5/R6: empty pop after reset replays 0x0000 and flags underflow
    step(0, '0, 1, 0);
    step(0, '0, 0, 0);
    // R6: flag sticks, then clears
    step(0, '0, 0, 0);
    step(0, '0, 0, 1);
    // R8: enables gate the empty levels
    irq_en = 1'b1;
    step(0, '0, 0, 0);
    dma_en = 1'b1;
    step(0, '0, 0, 0);
    // R2/R7: fill to four
    step(1, 16'hA001, 0, 0);
    step(1, 16'hA002, 0, 0);
    step(1, 16'hA003, 0, 0);
    step(1, 16'hA004, 0, 0);
    // R3: writes while full are dropped
    step(1, 16'hDEAD, 0, 0);
    step(1, 16'hBEEF, 0, 0);
    // R2: drain in order
    for (int i = 0; i < 4; i++) step(0, '0, 1, 0);
    step(0, '0, 0, 0);
    // R3/R5: replay is the last accepted word, not the dropped ones
    step(0, '0, 1, 0);
    step(0, '0, 1, 1);  // R6: clear and new underflow together, flag stays
    step(0, '0, 0, 1);  // R6: clear alone
    irq_en = 1'b0;
    // R9: push+pop on a partly filled store
    step(1, 16'hB001, 0, 0);
    step(1, 16'hB002, 0, 0);
    step(1, 16'hB003, 1, 0);
    step(1, 16'hB004, 1, 0);
    step(0, '0, 1, 0);
    step(0, '0, 1, 0);
    // R5: empty pop with a write in the same cycle: emits old replay, keeps new word
    step(1, 16'hC001, 1, 0);
    step(0, '0, 1, 0);
    step(0, '0, 1, 0);
    dma_en = 1'b0;
    step(0, '0, 0, 1);
    // R9: balanced traffic while full is not allowed to push; pop frees space
    for (int i = 0; i < 4; i++) step(1, 16'hD000 + 16'(i), 0, 0);
    step(1, 16'hD0FF, 1, 0);  // R3: full, write dropped, pop proceeds
    step(1, 16'hD100, 1, 0);  // R9: neither empty nor full now
    for (int i = 0; i < 5; i++) step(0, '0, 1, 0);
    step(0, '0, 0, 0);
    step(0, '0, 0, 0);
    // R4: every expected word was emitted
    check("R4 scoreboard drained", sb_q.size(), 0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule